// File: doc/BRIEF.md
# Chip-Select Wait-State Timing Generator

This block sits between an internal bus master and an external asynchronous peripheral that occupies one memory-mapped window. Each request carries an address, a direction and, for writes, a data word. The block compares the upper address bits against a programmable base under a programmable mask. A miss, or a request while the window is disabled, completes one clock later with a miss flag and drives no strobe. A hit starts an external cycle with an active-low chip select, an active-low read strobe and a read/write line.

The external cycle is built from clock counts so that the peripheral's timing rules can be met at a given clock rate. An optional setup cycle drives the address one clock before chip select, and on writes the read/write line also waits for that clock. The strobe stays low for the wait-state count plus two clocks, so a setting of 3 at 48 MHz gives a strobe of about 104 ns. After negation, an optional hold cycle keeps the address driven. Read hold and write hold are enabled separately, and a write hold also keeps the data driven. Read data is captured on the last strobe clock. A one-clock done pulse then returns the result. Requests that arrive before done are ignored.

Top module: `cs_waitgen`

## Requirements
- R1: An access hits when, for every bit i where cfg_mask[i] is 1, req_addr[12+i] equals cfg_base[i], and cfg_en is 1. With base 0x40000 and an all-ones mask, the window is the 4 KB at 0x40000000. Mask bits at 0 are not compared.
- R2: A miss, or any request while cfg_en is 0, raises rsp_done and rsp_miss together in the clock after the request edge. During that access bus_cs_n, bus_rd_n and bus_rw_n stay 1, and bus_addr_oe and bus_data_oe stay 0.
- R3: With cfg_aset at 1, bus_addr_oe rises one clock before bus_cs_n falls, and on writes bus_rw_n also stays 1 for that clock. With cfg_aset at 0, the address and chip select start in the same clock, which is the clock after the request edge. bus_addr carries the requested address whenever bus_addr_oe is 1.
- R4: bus_cs_n is 0 for exactly cfg_ws+2 clocks. A read holds bus_rd_n at 0 and bus_rw_n at 1 for those clocks. A write holds bus_rw_n at 0 (0 means write) and bus_rd_n at 1, and drives bus_wdata with the request data and bus_data_oe at 1.
- R5: With cfg_wrah at 1, a write keeps bus_addr_oe and bus_data_oe at 1 for one clock after bus_cs_n and bus_rw_n return to 1. With cfg_wrah at 0, both drop when bus_cs_n returns to 1.
- R6: With cfg_rdah at 1, a read keeps bus_addr_oe at 1 for one clock after bus_cs_n returns to 1. bus_data_oe is never 1 during a read.
- R7: rsp_done is a one-clock pulse in the clock after the last hold clock, or after the last strobe clock if there is no hold. Counted from the request edge, it arrives after 1+aset+(ws+2)+hold clocks. On a read hit, rsp_rdata then holds the bus_rdata value sampled on the last strobe clock.
- R8: A request that arrives while an access is in progress is ignored. It makes no done pulse and does not change the address being driven.
- R9: After reset bus_cs_n, bus_rd_n and bus_rw_n are 1, and bus_addr_oe, bus_data_oe, rsp_done and rsp_miss are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Window enable |
| cfg_base | input | 20 | Window base, compared with address bits 31:12 |
| cfg_mask | input | 20 | Per-bit compare mask for the base |
| cfg_ws | input | 5 | Wait-state count |
| cfg_aset | input | 1 | Address setup cycle enable |
| cfg_rdah | input | 1 | Read hold cycle enable |
| cfg_wrah | input | 1 | Write hold cycle enable |
| req | input | 1 | Request, sampled while idle |
| req_addr | input | 32 | Request byte address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_miss | output | 1 | Completion was a window miss |
| rsp_rdata | output | 16 | Captured read data |
| bus_cs_n | output | 1 | External chip select, active low |
| bus_rd_n | output | 1 | External read strobe, active low |
| bus_rw_n | output | 1 | External read/write line, low for write |
| bus_addr | output | 32 | External address |
| bus_addr_oe | output | 1 | Address drive enable |
| bus_wdata | output | 16 | External write data |
| bus_data_oe | output | 1 | Data drive enable |
| bus_rdata | input | 16 | External read data |

## Verification
Reads and writes at the working setting of 3 wait states with every option on are compared with runs that have no setup, no hold and zero wait states. This separates the fixed parts of the cycle from the programmable ones, and a wait-state count of 0x1F tests the top of the counter. Read hold and write hold are switched on one at a time, which shows that each applies only to its own direction and that only write hold keeps the data driven. Window misses, a disabled window and a partial mask each test a separate branch of the decoder. A request sent in the middle of a write checks that requests are ignored while an access is in progress.

// File: rtl/cs_pkg.sv
package cs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STROBE = 3'd2,
      ST_HOLD   = 3'd3,
      ST_FIN    = 3'd4
   } cs_state_e;
endpackage

// File: rtl/cs_match.sv
module cs_match #(
   parameter int ADDR_W   = 32,
   parameter int MASK_LSB = 12,
   localparam int FW      = ADDR_W - MASK_LSB
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [FW-1:0]     base,
   input  logic [FW-1:0]     mask,
   input  logic              en,
   output logic              hit
);
   logic [FW-1:0] diff;

   for (genvar gi = 0; gi < FW; gi++) begin : g_bit
      assign diff[gi] = (addr[MASK_LSB+gi] ^ base[gi]) & mask[gi];
   end

   assign hit = en && (diff == '0);
endmodule

// File: rtl/cs_seq.sv
module cs_seq
   import cs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 16,
   parameter int WS_W   = 5,
   localparam int CNT_W = WS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              hit,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WS_W-1:0]   cfg_ws,
   input  logic              cfg_aset,
   input  logic              cfg_rdah,
   input  logic              cfg_wrah,
   input  logic [DATA_W-1:0] bus_rdata,
   output cs_state_e         state,
   output logic              wr_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              miss_q,
   output logic [DATA_W-1:0] rdata_q
);
   logic [CNT_W-1:0] cnt_q;
   logic             hold_q;
   logic             last_strobe;

   assign last_strobe = (state == ST_STROBE) && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt_q   <= '0;
         hold_q  <= 1'b0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         miss_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req) begin
                  if (hit) begin
                     addr_q  <= req_addr;
                     wr_q    <= req_wr;
                     wdata_q <= req_wdata;
                     hold_q  <= req_wr ? cfg_wrah : cfg_rdah;
                     cnt_q   <= {1'b0, cfg_ws} + CNT_W'(1);
                     miss_q  <= 1'b0;
                     state   <= cfg_aset ? ST_SETUP : ST_STROBE;
                  end else begin
                     miss_q  <= 1'b1;
                     state   <= ST_FIN;
                  end
               end
            end
            ST_SETUP: state <= ST_STROBE;
            ST_STROBE: begin
               if (last_strobe) begin
                  if (!wr_q) rdata_q <= bus_rdata;
                  state <= hold_q ? ST_HOLD : ST_FIN;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_HOLD: state <= ST_FIN;
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cs_pins.sv
module cs_pins
   import cs_pkg::*;
(
   input  cs_state_e state,
   input  logic      wr_q,
   input  logic      miss_q,
   output logic      cs_n,
   output logic      rd_n,
   output logic      rw_n,
   output logic      addr_oe,
   output logic      data_oe,
   output logic      done,
   output logic      miss
);
   logic strobe;
   assign strobe  = (state == ST_STROBE);
   assign cs_n    = !strobe;
   assign rd_n    = !(strobe && !wr_q);
   assign rw_n    = !(strobe && wr_q);
   assign addr_oe = (state == ST_SETUP) || strobe || (state == ST_HOLD);
   assign data_oe = wr_q && (strobe || (state == ST_HOLD));
   assign done    = (state == ST_FIN);
   assign miss    = done && miss_q;
endmodule

// File: rtl/cs_waitgen.sv
module cs_waitgen
   import cs_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 16,
   parameter int MASK_LSB = 12,
   parameter int WS_W     = 5,
   localparam int FW      = ADDR_W - MASK_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [FW-1:0]     cfg_base,
   input  logic [FW-1:0]     cfg_mask,
   input  logic [WS_W-1:0]   cfg_ws,
   input  logic              cfg_aset,
   input  logic              cfg_rdah,
   input  logic              cfg_wrah,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic              rsp_miss,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              bus_cs_n,
   output logic              bus_rd_n,
   output logic              bus_rw_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_addr_oe,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_data_oe,
   input  logic [DATA_W-1:0] bus_rdata
);
   if (MASK_LSB < 1 || MASK_LSB >= ADDR_W) begin : g_bad_lsb
      $error("cs_waitgen: MASK_LSB out of range");
   end
   if (WS_W < 1 || WS_W > 8) begin : g_bad_ws
      $error("cs_waitgen: WS_W out of range");
   end
   if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32) begin : g_bad_dw
      $error("cs_waitgen: DATA_W must be 8, 16 or 32");
   end

   logic      hit;
   cs_state_e state;
   logic      wr_q;
   logic      miss_q;

   cs_match #(.ADDR_W(ADDR_W), .MASK_LSB(MASK_LSB)) u_match (
      .addr(req_addr), .base(cfg_base), .mask(cfg_mask), .en(cfg_en), .hit(hit)
   );

   cs_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .hit(hit),
      .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
      .cfg_ws(cfg_ws), .cfg_aset(cfg_aset), .cfg_rdah(cfg_rdah), .cfg_wrah(cfg_wrah),
      .bus_rdata(bus_rdata), .state(state), .wr_q(wr_q), .addr_q(bus_addr),
      .wdata_q(bus_wdata), .miss_q(miss_q), .rdata_q(rsp_rdata)
   );

   cs_pins u_pins (
      .state(state), .wr_q(wr_q), .miss_q(miss_q),
      .cs_n(bus_cs_n), .rd_n(bus_rd_n), .rw_n(bus_rw_n),
      .addr_oe(bus_addr_oe), .data_oe(bus_data_oe),
      .done(rsp_done), .miss(rsp_miss)
   );
endmodule

// File: rtl/cs_waitgen_chk.sv
module cs_waitgen_chk #(
   parameter int WS_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [WS_W-1:0] cfg_ws,
   input logic            cfg_aset,
   input logic            rsp_done,
   input logic            rsp_miss,
   input logic            bus_cs_n,
   input logic            bus_rd_n,
   input logic            bus_rw_n,
   input logic            bus_addr_oe,
   input logic            bus_data_oe
);
   logic [WS_W+1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_cnt <= '0;
      else if (!bus_cs_n) low_cnt <= low_cnt + 1'b1;
      else low_cnt <= '0;
   end

   // R4
   cs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cs_n |-> bus_addr_oe);
   // R4
   rw_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rw_n |-> (!bus_cs_n && bus_rd_n));
   // R6
   rd_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_data_oe);
   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (bus_cs_n && !bus_addr_oe));
   // R2
   miss_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> rsp_done);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   // R3
   setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_cs_n) && cfg_aset) |-> $past(bus_addr_oe));
   // R4
   width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cs_n) |-> (low_cnt == ({2'b00, cfg_ws} + 2)));
endmodule

bind cs_waitgen cs_waitgen_chk #(.WS_W(WS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_ws(cfg_ws), .cfg_aset(cfg_aset),
   .rsp_done(rsp_done), .rsp_miss(rsp_miss), .bus_cs_n(bus_cs_n),
   .bus_rd_n(bus_rd_n), .bus_rw_n(bus_rw_n), .bus_addr_oe(bus_addr_oe),
   .bus_data_oe(bus_data_oe)
);

// File: tb/test_cs_waitgen.sv
module test_cs_waitgen;
   localparam int CLK_PERIOD = 20;

   typedef struct {
      logic        miss;
      logic        wr;
      logic [31:0] addr;
      logic [15:0] wdata;
      logic [15:0] rdata;
      int          lat;
      int          setup;
      int          csw;
      int          hold;
      int          dhold;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b1;
   logic [19:0] cfg_base = 20'h40000;
   logic [19:0] cfg_mask = 20'hFFFFF;
   logic [4:0]  cfg_ws = 5'd3;
   logic        cfg_aset = 1'b1, cfg_rdah = 1'b1, cfg_wrah = 1'b1;
   logic        req = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_wr = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done, rsp_miss;
   logic [15:0] rsp_rdata;
   logic        bus_cs_n, bus_rd_n, bus_rw_n, bus_addr_oe, bus_data_oe;
   logic [31:0] bus_addr;
   logic [15:0] bus_wdata, bus_rdata;

   int checks = 0;
   int fails  = 0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   assign bus_rdata = bus_addr[15:0] ^ 16'hA5C3;

   cs_waitgen i_cs_waitgen (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base(cfg_base),
      .cfg_mask(cfg_mask), .cfg_ws(cfg_ws), .cfg_aset(cfg_aset),
      .cfg_rdah(cfg_rdah), .cfg_wrah(cfg_wrah), .req(req), .req_addr(req_addr),
      .req_wr(req_wr), .req_wdata(req_wdata), .rsp_done(rsp_done),
      .rsp_miss(rsp_miss), .rsp_rdata(rsp_rdata), .bus_cs_n(bus_cs_n),
      .bus_rd_n(bus_rd_n), .bus_rw_n(bus_rw_n), .bus_addr(bus_addr),
      .bus_addr_oe(bus_addr_oe), .bus_wdata(bus_wdata),
      .bus_data_oe(bus_data_oe), .bus_rdata(bus_rdata)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic in_window(input logic [31:0] a);
      return cfg_en && (((a[31:12] ^ cfg_base) & cfg_mask) == 20'h0);
   endfunction

   task automatic push_exp(input logic [31:0] a, input logic w, input logic [15:0] d);
      exp_t e;
      int h;
      e.miss  = !in_window(a);
      e.wr    = w;
      e.addr  = a;
      e.wdata = d;
      e.rdata = a[15:0] ^ 16'hA5C3;
      h       = w ? int'(cfg_wrah) : int'(cfg_rdah);
      e.setup = e.miss ? 0 : int'(cfg_aset);
      e.csw   = e.miss ? 0 : int'(cfg_ws) + 2;
      e.hold  = e.miss ? 0 : h;
      e.dhold = (e.miss || !w) ? 0 : h;
      e.lat   = e.miss ? 1 : 1 + e.setup + e.csw + e.hold;
      q.push_back(e);
   endtask

   task automatic issue(input logic [31:0] a, input logic w, input logic [15:0] d);
      @(posedge clk); #1;
      req = 1'b1; req_addr = a; req_wr = w; req_wdata = d;
      @(posedge clk); #1;
      req = 1'b0; req_addr = 32'h0BAD_0000; req_wdata = 16'hDEAD;
   endtask

   task automatic wait_idle();
      while (q.size() != 0) @(posedge clk);
      repeat (2) @(posedge clk);
   endtask

   task automatic access(input logic [31:0] a, input logic w, input logic [15:0] d);
      push_exp(a, w, d);
      issue(a, w, d);
      wait_idle();
   endtask

   // monitor / scoreboard
   logic act = 1'b0;
   logic seen_cs;
   int   lat, n_setup, n_csw, n_hold, n_dhold, n_bad;
   logic [31:0] cur_addr;
   logic        cur_wr;
   logic [15:0] cur_wdata;

   always @(negedge clk) begin
      if (rst_n) begin
         if (act) begin
            lat++;
            if (bus_addr_oe && bus_addr != cur_addr) n_bad++;
            if (bus_addr_oe && bus_cs_n && !seen_cs) n_setup++;
            if (!bus_cs_n) begin
               seen_cs = 1'b1;
               n_csw++;
               if (bus_rw_n != !cur_wr || bus_rd_n != cur_wr) n_bad++;
               if (cur_wr && (!bus_data_oe || bus_wdata != cur_wdata)) n_bad++;
               if (!cur_wr && bus_data_oe) n_bad++;
            end else if (!bus_rd_n || !bus_rw_n) n_bad++;
            if (seen_cs && bus_cs_n && bus_addr_oe) n_hold++;
            if (seen_cs && bus_cs_n && bus_data_oe) n_dhold++;
            if (rsp_done) begin
               exp_t e;
               if (q.size() == 0) begin
                  check("R8 done with nothing pending", 1, 0);
               end else begin
                  e = q.pop_front();
                  check("R1/R2 miss flag", int'(rsp_miss), int'(e.miss));
                  check("R7 latency", lat, e.lat);
                  check("R3 setup clocks", n_setup, e.setup);
                  check("R4 strobe width", n_csw, e.csw);
                  check(e.wr ? "R5 write addr hold" : "R6 read addr hold", n_hold, e.hold);
                  check(e.wr ? "R5 write data hold" : "R6 read data off", n_dhold, e.dhold);
                  check("R4 strobe pins/address/data", n_bad, 0);
                  if (!e.miss && !e.wr) check("R7 read data", int'(rsp_rdata), int'(e.rdata));
               end
               act = 1'b0;
            end
         end else if (req) begin
            act = 1'b1; seen_cs = 1'b0;
            lat = 0; n_setup = 0; n_csw = 0; n_hold = 0; n_dhold = 0; n_bad = 0;
            cur_addr = req_addr; cur_wr = req_wr; cur_wdata = req_wdata;
         end else if (rsp_done) begin
            check("R8 done with no access", 1, 0);
         end
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      check("R9 cs_n", int'(bus_cs_n), 1);
      check("R9 rd_n", int'(bus_rd_n), 1);
      check("R9 rw_n", int'(bus_rw_n), 1);
      check("R9 oe/done", int'({bus_addr_oe, bus_data_oe, rsp_done, rsp_miss}), 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R4 R5 R6 R7 working setting, all options on
      access(32'h4000_0010, 1'b0, 16'h0);
      access(32'h4000_0020, 1'b1, 16'h1234);
      // R3 no setup, no hold, zero waits
      cfg_aset = 1'b0; cfg_rdah = 1'b0; cfg_wrah = 1'b0; cfg_ws = 5'd0;
      access(32'h4000_0FFC, 1'b0, 16'h0);
      access(32'h4000_0004, 1'b1, 16'hBEEF);
      // R4 bring-up wait count
      cfg_aset = 1'b1; cfg_ws = 5'h1F;
      access(32'h4000_0100, 1'b0, 16'h0);
      // R6 read hold only / R5 write hold off
      cfg_ws = 5'd2; cfg_rdah = 1'b1; cfg_wrah = 1'b0;
      access(32'h4000_0200, 1'b1, 16'h5A5A);
      access(32'h4000_0204, 1'b0, 16'h0);
      // R5 write hold only
      cfg_rdah = 1'b0; cfg_wrah = 1'b1;
      access(32'h4000_0208, 1'b1, 16'hC001);
      access(32'h4000_020C, 1'b0, 16'h0);
      // R2 miss just above the window
      access(32'h4000_1000, 1'b0, 16'h0);
      access(32'h3FFF_FFFC, 1'b1, 16'h7777);
      // R2 disabled window
      cfg_en = 1'b0;
      access(32'h4000_0010, 1'b1, 16'h4444);
      cfg_en = 1'b1;
      // R1 partial mask ignores bits 15:12
      cfg_mask = 20'hFFFF0;
      access(32'h4000_A004, 1'b0, 16'h0);
      access(32'h4001_A004, 1'b0, 16'h0);
      cfg_mask = 20'hFFFFF;
      // R8 request during a write is ignored
      cfg_ws = 5'd3; cfg_aset = 1'b1; cfg_wrah = 1'b1;
      push_exp(32'h4000_0040, 1'b1, 16'h9999);
      issue(32'h4000_0040, 1'b1, 16'h9999);
      @(posedge clk); #1;
      req = 1'b1; req_addr = 32'h4000_0080; req_wr = 1'b0;
      @(posedge clk); #1;
      req = 1'b0;
      wait_idle();
      repeat (5) @(posedge clk);
      check("R8 queue drained", q.size(), 0);
      finish_run();
   end
endmodule